// File: doc/BRIEF.md
# Indexed element remap sequencer

This block walks a fixed-length vector of 32-bit elements one element at a time. For each element it issues an operation slot: a destination index, two source indices and a rotate amount. The indices are not counted linearly. Each one is looked up in a packed table of byte-wide offsets, and the offset is added to a base register number. A separate four-entry table supplies the rotate amount, and it repeats every four elements whatever the element count.

Software fills three index tables and the shift table through a word-wide load port while the block is idle. It then pulses start with a base register number and an outer repeat count. The sequencer emits the whole sweep of 32 slots on a valid/ready stream, flags the last slot of each sweep, and restarts the sweep until the outer count is used up. A typical use runs a quarter-round schedule that alternates columns and diagonals, with ten outer passes.

Top module: `remap_seq`

## Requirements
- R1: After reset, stepValid, lastElem and finalPass are low.
- R2: While stepValid is high, a load pulse has no effect. The bench checks this by observing the indices issued after such a load. The load port selects its table with loadSel: 0 destination, 1 source A, 2 source B, 3 shift. loadAddr picks the 64-bit word (0..3 for an index table, 0..1 for the shift table).
- R3: A start pulse is accepted only when the sequencer is idle, all 14 table words have been written since reset, and outerCount is nonzero. Any other start pulse has no effect.
- R4: Element e takes byte e mod 8 of word e div 8 of each index table, and byte 0 is bits 7:0.
- R5: Each issued index is baseReg plus the table byte, modulo 256. baseReg is sampled only in the cycle in which start is accepted.
- R6: shiftAmt is the low 5 bits of the 32-bit shift entry e mod 4. Entry 0 is bits 31:0 of shift word 0, entry 1 is bits 63:32 of word 0, and entries 2 and 3 sit in the same way in word 1.
- R7: Element 0 is valid in the cycle after start is accepted. The outputs hold steady while stepValid is high and stepReady is low. The sequencer moves to the next element only on a handshake.
- R8: lastElem is high exactly while element 31 is presented.
- R9: After a handshake on element 31, element 0 follows in the next cycle if passes remain. After outerCount passes, stepValid falls. finalPass is high throughout the last pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Table word write strobe |
| loadSel | input | 2 | Table select (0 dst, 1 srcA, 2 srcB, 3 shift) |
| loadAddr | input | 2 | Word within the selected table |
| loadData | input | 64 | Packed table word |
| start | input | 1 | Start strobe |
| baseReg | input | 8 | Base register number, sampled on start |
| outerCount | input | 8 | Number of full sweeps |
| stepReady | input | 1 | Consumer accepts the current slot |
| stepValid | output | 1 | Slot valid |
| dstIdx | output | 8 | Destination register index |
| srcAIdx | output | 8 | First source register index |
| srcBIdx | output | 8 | Second source register index |
| shiftAmt | output | 5 | Rotate amount for this slot |
| lastElem | output | 1 | Slot is element 31 of the sweep |
| finalPass | output | 1 | Slot belongs to the last sweep |

## Verification
The assertions assume that start pulses only when the tables are complete, or that a rejected start leaves stepValid low. They also assume that stepReady may change in any cycle, with no link to stepValid. The bench drives every input on the falling edge. It stalls the stream with a pseudo-random ready pattern, so the hold and wrap properties see both stalled and flowing cycles. During a sweep it deliberately pulses start, writes a garbage table word and changes baseReg, so that the ignored-input rules are tested on inputs that do move.

// File: rtl/remap_pkg.sv
package remap_pkg;
  parameter int VEC_LEN     = 32;
  parameter int IDX_W       = 8;
  parameter int WORD_W      = 64;
  parameter int SHIFT_W     = 5;
  parameter int SHIFT_MOD   = 4;
  parameter int SHIFT_ENT_W = 32;
  parameter int OUTER_W     = 8;
  parameter int NUM_IDX_TBL = 3;

  localparam int IDX_PER_WORD = WORD_W / IDX_W;
  localparam int TBL_WORDS    = VEC_LEN / IDX_PER_WORD;
  localparam int ELEM_W       = $clog2(VEC_LEN);
  localparam int BYTE_SEL_W   = $clog2(IDX_PER_WORD);
  localparam int ADDR_W       = $clog2(TBL_WORDS);
  localparam int SH_PER_WORD  = WORD_W / SHIFT_ENT_W;
  localparam int SH_WORDS     = SHIFT_MOD / SH_PER_WORD;
  localparam int SH_SEL_W     = $clog2(SHIFT_MOD);
  localparam int SH_HALF_W    = $clog2(SH_PER_WORD);
  localparam int SH_AW        = $clog2(SH_WORDS);
  localparam int LOAD_WORDS   = NUM_IDX_TBL * TBL_WORDS + SH_WORDS;
  localparam logic [1:0] SHIFT_SEL = 2'(NUM_IDX_TBL);

  typedef struct packed {
    logic              tblWrite;
    logic              issue;
    logic              capBase;
    logic [ELEM_W-1:0] elemSel;
  } ctrlStrb_t;
endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic [1:0]         loadSel,
  input  logic [ADDR_W-1:0]  loadAddr,
  input  logic               start,
  input  logic [OUTER_W-1:0] outerCount,
  input  logic               stepReady,
  output logic               stepValid,
  output logic               lastElem,
  output logic               finalPass,
  output ctrlStrb_t          strb
);
  logic                  running;
  logic [ELEM_W-1:0]     elemCnt;
  logic [OUTER_W-1:0]    passLeft;
  logic [LOAD_WORDS-1:0] loadedMask;
  logic                  addrOk, handshake, isLast, noMore, startOk;
  int                    maskIdx;

  always_comb begin
    addrOk    = (loadSel != SHIFT_SEL) || (loadAddr < ADDR_W'(SH_WORDS));
    maskIdx   = int'(loadSel) * TBL_WORDS + int'(loadAddr);
    handshake = running && stepReady;
    isLast    = elemCnt == ELEM_W'(VEC_LEN - 1);
    noMore    = passLeft == '0;
    startOk   = start && !running && (&loadedMask) && (outerCount != '0);

    strb.tblWrite = loadEn && !running && addrOk;
    strb.capBase  = startOk;
    strb.issue    = startOk || (handshake && !(isLast && noMore));
    if (startOk || isLast) strb.elemSel = '0;
    else                   strb.elemSel = elemCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running    <= 1'b0;
      elemCnt    <= '0;
      passLeft   <= '0;
      loadedMask <= '0;
    end else begin
      for (int w = 0; w < LOAD_WORDS; w++)
        if (strb.tblWrite && maskIdx == w) loadedMask[w] <= 1'b1;
      if (startOk) begin
        running  <= 1'b1;
        elemCnt  <= '0;
        passLeft <= outerCount - 1'b1;
      end else if (handshake) begin
        if (isLast) begin
          elemCnt <= '0;
          if (noMore) running  <= 1'b0;
          else        passLeft <= passLeft - 1'b1;
        end else begin
          elemCnt <= elemCnt + 1'b1;
        end
      end
    end
  end

  assign stepValid = running;
  assign lastElem  = running && isLast;
  assign finalPass = running && noMore;
endmodule

// File: rtl/remap_data.sv
module remap_data
  import remap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [1:0]         loadSel,
  input  logic [ADDR_W-1:0]  loadAddr,
  input  logic [WORD_W-1:0]  loadData,
  input  logic [IDX_W-1:0]   baseReg,
  output logic [IDX_W-1:0]   dstIdx,
  output logic [IDX_W-1:0]   srcAIdx,
  output logic [IDX_W-1:0]   srcBIdx,
  output logic [SHIFT_W-1:0] shiftAmt
);
  logic [WORD_W-1:0] idxTbl [NUM_IDX_TBL][TBL_WORDS];
  logic [WORD_W-1:0] shTbl  [SH_WORDS];
  logic [IDX_W-1:0]  entry  [NUM_IDX_TBL];
  logic [IDX_W-1:0]  baseQ, baseEff;
  logic [ELEM_W-BYTE_SEL_W-1:0] wordSel;
  logic [BYTE_SEL_W-1:0]        byteSel;
  logic [SH_SEL_W-1:0]          shSel;
  logic [SHIFT_ENT_W-1:0]       shEntry;

  always_ff @(posedge clk) begin
    if (strb.tblWrite) begin
      if (loadSel == SHIFT_SEL) shTbl[loadAddr[SH_AW-1:0]] <= loadData;
      else                      idxTbl[loadSel][loadAddr] <= loadData;
    end
  end

  assign wordSel = strb.elemSel[ELEM_W-1:BYTE_SEL_W];
  assign byteSel = strb.elemSel[BYTE_SEL_W-1:0];
  assign shSel   = strb.elemSel[SH_SEL_W-1:0];
  assign baseEff = strb.capBase ? baseReg : baseQ;

  for (genvar t = 0; t < NUM_IDX_TBL; t++) begin : g_unpack
    assign entry[t] = idxTbl[t][wordSel][int'(byteSel) * IDX_W +: IDX_W];
  end

  assign shEntry = shTbl[shSel[SH_SEL_W-1:SH_HALF_W]]
                        [int'(shSel[SH_HALF_W-1:0]) * SHIFT_ENT_W +: SHIFT_ENT_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ    <= '0;
      dstIdx   <= '0;
      srcAIdx  <= '0;
      srcBIdx  <= '0;
      shiftAmt <= '0;
    end else begin
      if (strb.capBase) baseQ <= baseReg;
      if (strb.issue) begin
        dstIdx   <= baseEff + entry[0];
        srcAIdx  <= baseEff + entry[1];
        srcBIdx  <= baseEff + entry[2];
        shiftAmt <= shEntry[SHIFT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/remap_seq.sv
module remap_seq
  import remap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic [1:0]         loadSel,
  input  logic [ADDR_W-1:0]  loadAddr,
  input  logic [WORD_W-1:0]  loadData,
  input  logic               start,
  input  logic [IDX_W-1:0]   baseReg,
  input  logic [OUTER_W-1:0] outerCount,
  input  logic               stepReady,
  output logic               stepValid,
  output logic [IDX_W-1:0]   dstIdx,
  output logic [IDX_W-1:0]   srcAIdx,
  output logic [IDX_W-1:0]   srcBIdx,
  output logic [SHIFT_W-1:0] shiftAmt,
  output logic               lastElem,
  output logic               finalPass
);
  ctrlStrb_t strb;

  remap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadSel(loadSel),
    .loadAddr(loadAddr), .start(start), .outerCount(outerCount),
    .stepReady(stepReady), .stepValid(stepValid), .lastElem(lastElem),
    .finalPass(finalPass), .strb(strb)
  );

  remap_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .loadSel(loadSel),
    .loadAddr(loadAddr), .loadData(loadData), .baseReg(baseReg),
    .dstIdx(dstIdx), .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
    .shiftAmt(shiftAmt)
  );
endmodule

// File: rtl/remap_seq_chk.sv
module remap_seq_chk
  import remap_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               stepReady,
  input logic               stepValid,
  input logic [IDX_W-1:0]   dstIdx,
  input logic [IDX_W-1:0]   srcAIdx,
  input logic [IDX_W-1:0]   srcBIdx,
  input logic [SHIFT_W-1:0] shiftAmt,
  input logic               lastElem,
  input logic               finalPass
);
  logic [ELEM_W-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rstN || !stepValid) seen <= '0;
    else if (stepReady)      seen <= seen + 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !stepValid |-> (!lastElem && !finalPass));

  assert_start_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stepValid) |-> $past(start));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && !stepReady) |=> (stepValid && $stable(dstIdx) && $stable(srcAIdx)
      && $stable(srcBIdx) && $stable(shiftAmt) && $stable(lastElem)));

  assert_last_slot_R8: assert property (@(posedge clk) disable iff (!rstN)
    stepValid |-> (lastElem == (seen == ELEM_W'(VEC_LEN - 1))));

  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && stepReady && lastElem && !finalPass) |=> (stepValid && !lastElem));

  assert_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stepValid && stepReady && lastElem && finalPass) |=> !stepValid);

  assert_final_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (finalPass && !(stepReady && lastElem)) |=> finalPass);
endmodule

bind remap_seq remap_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .stepReady(stepReady),
  .stepValid(stepValid), .dstIdx(dstIdx), .srcAIdx(srcAIdx), .srcBIdx(srcBIdx),
  .shiftAmt(shiftAmt), .lastElem(lastElem), .finalPass(finalPass)
);

// File: tb/remap_seq_test.sv
module remap_seq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic [1:0]  loadSel = '0;
  logic [1:0]  loadAddr = '0;
  logic [63:0] loadData = '0;
  logic        start = 1'b0;
  logic [7:0]  baseReg = '0;
  logic [7:0]  outerCount = '0;
  logic        stepReady = 1'b0;
  logic        stepValid, lastElem, finalPass;
  logic [7:0]  dstIdx, srcAIdx, srcBIdx;
  logic [4:0]  shiftAmt;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  int tblByte [3][32];
  int shiftVal [4] = '{16, 12, 8, 7};

  always #2 clk = ~clk;

  remap_seq uut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadSel(loadSel),
    .loadAddr(loadAddr), .loadData(loadData), .start(start), .baseReg(baseReg),
    .outerCount(outerCount), .stepReady(stepReady), .stepValid(stepValid),
    .dstIdx(dstIdx), .srcAIdx(srcAIdx), .srcBIdx(srcBIdx), .shiftAmt(shiftAmt),
    .lastElem(lastElem), .finalPass(finalPass)
  );

  task automatic check(string req, int actual, int expected);
    tests++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, actual, expected, cycles);
    end
  endtask

  function automatic logic [63:0] packWord(int t, int w);
    logic [63:0] v = '0;
    for (int j = 0; j < 8; j++) v[j*8 +: 8] = 8'(tblByte[t][w*8 + j]);
    return v;
  endfunction

  task automatic writeWord(int sel, int addr, logic [63:0] data);
    @(negedge clk);
    loadEn = 1'b1; loadSel = 2'(sel); loadAddr = 2'(addr); loadData = data;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic pulseStartExpectIdle(string req, int outer);
    @(negedge clk);
    outerCount = 8'(outer); baseReg = 8'd24; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(req, stepValid, 0);
    @(negedge clk);
    check(req, stepValid, 0);
  endtask

  task automatic runSweep(int outer, int base, bit randReady, bit disturb);
    int total = outer * 32;
    int hs = 0;
    int e;
    bit expV;
    @(negedge clk);
    baseReg = 8'(base); outerCount = 8'(outer); start = 1'b1; stepReady = 1'b0;
    @(negedge clk);
    start = 1'b0;
    while (!done) begin
      if (hs > 0) @(negedge clk);
      expV = hs < total;
      e = hs % 32;
      check("R7 valid", stepValid, int'(expV));
      if (!expV) begin
        check("R8 last idle", lastElem, 0);
        check("R9 final idle", finalPass, 0);
        break;
      end
      check("R4 R5 dst", dstIdx, (base + tblByte[0][e]) % 256);
      check("R4 R5 srcA", srcAIdx, (base + tblByte[1][e]) % 256);
      check("R4 R5 srcB", srcBIdx, (base + tblByte[2][e]) % 256);
      check("R6 shift", shiftAmt, shiftVal[e % 4]);
      check("R8 lastElem", lastElem, int'(e == 31));
      check("R9 finalPass", finalPass, int'(hs >= total - 32));
      // R2 R3 R5: during the sweep, disturb load port, start and base
      if (disturb && hs == 40) begin
        loadEn = 1'b1; loadSel = 2'd0; loadAddr = 2'd0; loadData = 64'hFFFF_FFFF_FFFF_FFFF;
        start = 1'b1; baseReg = ~8'(base);
      end else begin
        loadEn = 1'b0; start = 1'b0;
      end
      stepReady = randReady ? (($urandom % 3) != 0) : 1'b1;
      if (stepReady) hs++;
      if (hs == 0) @(negedge clk);
      if (hs == 0) begin
        // stay on element 0 until accepted
        while (!done && !stepReady) begin
          check("R7 hold", dstIdx, (base + tblByte[0][0]) % 256);
          stepReady = (($urandom % 3) != 0);
          if (!stepReady) @(negedge clk);
        end
        hs = 1;
      end
    end
    loadEn = 1'b0; start = 1'b0; stepReady = 1'b0;
  endtask

  initial begin
    for (int q = 0; q < 8; q++) begin
      int i = q % 4;
      int a = i, b, c, d;
      if (q < 4) begin b = 4 + i; c = 8 + i; d = 12 + i; end
      else begin b = 4 + (i + 1) % 4; c = 8 + (i + 2) % 4; d = 12 + (i + 3) % 4; end
      for (int k = 0; k < 4; k++) begin
        tblByte[0][q*4 + k] = (k % 2 == 0) ? a : c;
        tblByte[1][q*4 + k] = (k % 2 == 0) ? d : b;
        tblByte[2][q*4 + k] = (k % 2 == 0) ? b : d;
      end
    end

    repeat (3) @(negedge clk);
    check("R1 valid", stepValid, 0);
    check("R1 last", lastElem, 0);
    check("R1 final", finalPass, 0);
    rstN = 1'b1;

    for (int t = 0; t < 3; t++)
      for (int w = 0; w < 4; w++) writeWord(t, w, packWord(t, w));
    writeWord(3, 0, {32'd12, 32'd16});
    pulseStartExpectIdle("R3 incomplete tables", 2);
    writeWord(3, 1, {32'd7, 32'd8});
    pulseStartExpectIdle("R3 zero outer", 0);

    runSweep(2, 24, 1'b0, 1'b0);
    runSweep(3, 0, 1'b1, 1'b1);
    runSweep(1, 240, 1'b1, 1'b0);
    runSweep(10, 100, 1'b0, 1'b0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule